// File: doc/BRIEF.md
# DMA Strobe Handshake Sequencer

This block is a clocked state machine that moves one byte per DMA cycle across an internal data bus shared by two peripheral chips. One is a FIFO-based bus-interface chip, strobed by `dtr_o`. The other is an instrument-bus talker/listener chip, strobed by `iogo_o`. The state code is also the output vector. Each strobe, the wait-counter enable and the reset acknowledge are single bits of the state register, so every output is registered and glitch-free.

After reset the machine circles an idle loop. It starts a cycle only when the synchronized `pause_i` is low and the synchronized `ready_i` is high. The synchronized `read_i` selects the direction at that moment. A started cycle runs on its own to the end; only a reset can cut it short. Each step lasts one clock. The fixed number of steps that each strobe is held is sized to cover the data delay and accept times of the two chips.

Top module: `dma_strobe_seq`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0x04. A high `reset_i` at a rising edge loads 0x04 at that edge, from any state. In 0x04, `rst_ack_o` is 1 and `dtr_o`, `iogo_o` and `count_o` are 0.
- R2: From 0x04 with `reset_i` low, the machine goes to 0x00. It then steps 0x00 → 0x01 → 0x03. From 0x03 it returns to 0x00 unless a cycle starts. No strobe is asserted in these states.
- R3: `ready_i`, `pause_i` and `read_i` each pass through a two-flop synchronizer. A cycle starts from 0x03 only when the synchronized pause is 0 and the synchronized ready is 1.
- R4: With synchronized read = 0, a cycle is the write sequence 0x20, 0x21, 0x22, 0xA0, 0xA1, 0x80, followed by 0x00.
- R5: With synchronized read = 1, a cycle is the read sequence 0xA8, 0xA9, 0xAA, 0xAB, 0x80, followed by 0x00.
- R6: The outputs map to state bits as follows:
  - `iogo_o` is bit 7.
  - `dtr_o` is bit 5.
  - `count_o` is bit 3.
  - `rst_ack_o` is bit 2.
  - `qual_o` is bits 1:0.
- R7: Once a cycle has started, changes on `pause_i`, `ready_i` and `read_i` do not alter its sequence or its length.
- R8: `done_o` is high for exactly one clock, in the cycle where the state is 0x00 right after 0x80. It is low at every other time.
- R9: A `reset_i` during a cycle moves the machine to 0x04 at the next edge, and no `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one state per period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_i | input | 1 | Synchronous force to the reset state |
| pause_i | input | 1 | Hold the machine in idle when high |
| ready_i | input | 1 | Both chips can accept a byte |
| read_i | input | 1 | Direction: 1 = read sequence, 0 = write sequence |
| dtr_o | output | 1 | Strobe to the FIFO interface chip |
| iogo_o | output | 1 | Strobe to the instrument-bus chip |
| count_o | output | 1 | Wait-counter enable |
| rst_ack_o | output | 1 | Reset acknowledge |
| qual_o | output | 2 | Wait qualifier bits |
| state_o | output | 8 | Current state code |
| done_o | output | 1 | One-clock pulse at cycle completion |

## Verification
The expected timing of each result is as follows:
- **Reset:** A `reset_i` sampled at an edge shows as 0x04 in `state_o` right after that edge.
- **Input changes:** A change on `ready_i`, `pause_i` or `read_i` is first seen by the state logic two edges later. It affects the state only when the machine next leaves 0x03.
- **Outputs:** Every output bit moves in the same cycle as the state, because it is a bit of the state.
- **Completion:** `done_o` rises at the edge that loads 0x00 from 0x80.

The bench drives inputs at falling edges and samples at the following falling edge. It keeps a two-stage input pipeline and a state model of its own, so every sample is compared against the value due in exactly that cycle.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int STATE_W  = 8;
  localparam int IOGO_BIT = 7;
  localparam int DTR_BIT  = 5;
  localparam int CNT_BIT  = 3;
  localparam int RACK_BIT = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE0 = 8'h00,
    ST_IDLE1 = 8'h01,
    ST_IDLE2 = 8'h03,
    ST_RST   = 8'h04,
    ST_WR0   = 8'h20,
    ST_WR1   = 8'h21,
    ST_WR2   = 8'h22,
    ST_WG0   = 8'hA0,
    ST_WG1   = 8'hA1,
    ST_HOLD  = 8'h80,
    ST_RD0   = 8'hA8,
    ST_RD1   = 8'hA9,
    ST_RD2   = 8'hAA,
    ST_RD3   = 8'hAB
  } state_e;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/dss_fsm.sv
module dss_fsm
  import dss_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   reset_i,
  input  logic   go_i,
  input  logic   read_i,
  output state_e state_o,
  output logic   done_o
);
  state_e state_q, state_d;
  logic   done_q;

  always_comb begin
    state_d = ST_RST;
    if (!reset_i) begin
      unique case (state_q)
        ST_RST:   state_d = ST_IDLE0;
        ST_IDLE0: state_d = ST_IDLE1;
        ST_IDLE1: state_d = ST_IDLE2;
        ST_IDLE2: state_d = !go_i ? ST_IDLE0 : (read_i ? ST_RD0 : ST_WR0);
        ST_WR0:   state_d = ST_WR1;
        ST_WR1:   state_d = ST_WR2;
        ST_WR2:   state_d = ST_WG0;
        ST_WG0:   state_d = ST_WG1;
        ST_WG1:   state_d = ST_HOLD;
        ST_RD0:   state_d = ST_RD1;
        ST_RD1:   state_d = ST_RD2;
        ST_RD2:   state_d = ST_RD3;
        ST_RD3:   state_d = ST_HOLD;
        ST_HOLD:  state_d = ST_IDLE0;
        default:  state_d = ST_RST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_HOLD) && (state_d == ST_IDLE0);
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  AST_RESET_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_i |=> state_q == ST_RST); // R1
  AST_IDLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE0 && !reset_i) |=> state_q == ST_IDLE1); // R2
  AST_WRITE_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WG1 && !reset_i) |=> state_q == ST_HOLD); // R4
  AST_READ_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD3 && !reset_i) |=> state_q == ST_HOLD); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DONE_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(state_q) == ST_HOLD); // R8
  AST_ABORT_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_i |=> !done_q); // R9
endmodule

// File: rtl/dma_strobe_seq.sv
module dma_strobe_seq
  import dss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reset_i,
  input  logic       pause_i,
  input  logic       ready_i,
  input  logic       read_i,
  output logic       dtr_o,
  output logic       iogo_o,
  output logic       count_o,
  output logic       rst_ack_o,
  output logic [1:0] qual_o,
  output logic [7:0] state_o,
  output logic       done_o
);
  localparam int IN_W = 3;

  logic [IN_W-1:0] raw, syn;
  state_e          state;

  assign raw = {read_i, ready_i, pause_i};

  dss_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  dss_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reset_i (reset_i),
    .go_i    (syn[1] & ~syn[0]),
    .read_i  (syn[2]),
    .state_o (state),
    .done_o  (done_o)
  );

  // outputs are raw state bits: registered, no decode
  assign state_o   = state;
  assign iogo_o    = state[IOGO_BIT];
  assign dtr_o     = state[DTR_BIT];
  assign count_o   = state[CNT_BIT];
  assign rst_ack_o = state[RACK_BIT];
  assign qual_o    = state[1:0];

  AST_RACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ack_o |-> !(dtr_o || iogo_o || count_o)); // R1
  AST_COUNT_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o |-> (dtr_o && iogo_o)); // R6
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 8'h03 && !reset_i && (syn[0] || !syn[1])) |=> state_o == 8'h00); // R3
  AST_CYCLE_FREE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 8'hA8 && !reset_i) |=> state_o == 8'hA9); // R7
endmodule

// File: tb/dma_strobe_seq_tb_top.sv
module dma_strobe_seq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reset_i = 1'b0, pause_i = 1'b1, ready_i = 1'b0, read_i = 1'b0;
  logic dtr_o, iogo_o, count_o, rst_ack_o, done_o;
  logic [1:0] qual_o;
  logic [7:0] state_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  dma_strobe_seq dut_i (
    .clk_i, .rst_ni, .reset_i, .pause_i, .ready_i, .read_i,
    .dtr_o, .iogo_o, .count_o, .rst_ack_o, .qual_o, .state_o, .done_o
  );

  // bench model
  logic [2:0] m_s1 = '0, m_s2 = '0; // {read,ready,pause}
  logic [7:0] m_st = 8'h04;
  logic       m_done = 1'b0;

  function automatic logic [7:0] nxt(logic [7:0] s, logic rst, logic go, logic rd);
    if (rst) return 8'h04;
    case (s)
      8'h04: return 8'h00;
      8'h00: return 8'h01;
      8'h01: return 8'h03;
      8'h03: return !go ? 8'h00 : (rd ? 8'hA8 : 8'h20);
      8'h20: return 8'h21;
      8'h21: return 8'h22;
      8'h22: return 8'hA0;
      8'hA0: return 8'hA1;
      8'hA1: return 8'h80;
      8'hA8: return 8'hA9;
      8'hA9: return 8'hAA;
      8'hAA: return 8'hAB;
      8'hAB: return 8'h80;
      8'h80: return 8'h00;
      default: return 8'h04;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] s);
    case (s)
      8'h04: return "R1";
      8'h00, 8'h01, 8'h03: return "R2";
      8'h20, 8'h21, 8'h22, 8'hA0, 8'hA1: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [7:0] ns;
    @(posedge clk_i);
    if (!rst_ni) begin
      m_s1 = '0; m_s2 = '0; m_st = 8'h04; m_done = 1'b0;
    end else begin
      ns     = nxt(m_st, reset_i, m_s2[1] & ~m_s2[0], m_s2[2]);
      m_done = (m_st == 8'h80) && (ns == 8'h00);
      m_st   = ns;
      m_s2   = m_s1;
      m_s1   = {read_i, ready_i, pause_i};
    end
    @(negedge clk_i);
    chk(tag_of(m_st), state_o, m_st);
    chk("R8", done_o, m_done);
    chk("R6", {iogo_o, dtr_o, count_o, rst_ack_o, qual_o},
        {m_st[7], m_st[5], m_st[3], m_st[2], m_st[1:0]});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_state(input logic [7:0] code, input int lim);
    for (int i = 0; i < lim && state_o !== code; i++) tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] wr_seq [7];
    logic [7:0] rd_seq [6];
    int   starts;
    void'($urandom(32'd4051));
    wr_seq = '{8'h20, 8'h21, 8'h22, 8'hA0, 8'hA1, 8'h80, 8'h00};
    rd_seq = '{8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'h80, 8'h00};

    // R1: reset state
    ticks(3);
    chk("R1", {state_o, rst_ack_o, dtr_o, iogo_o, count_o}, {8'h04, 4'b1000});
    rst_ni = 1'b1;

    // R3: paused, ready high -> never leaves idle
    ready_i = 1'b1; pause_i = 1'b1;
    starts = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (state_o != 8'h00 && state_o != 8'h01 && state_o != 8'h03 && state_o != 8'h04) starts++;
    end
    chk("R3", starts, 0);
    // R3: not ready, unpaused -> still idle
    ready_i = 1'b0; pause_i = 1'b0;
    starts = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (state_o[7] | state_o[5]) starts++;
    end
    chk("R3", starts, 0);

    // R4: write sequence
    read_i = 1'b0; ready_i = 1'b1;
    wait_state(8'h20, 20);
    for (int i = 0; i < 7; i++) begin
      chk("R4", state_o, wr_seq[i]);
      if (i < 6) begin
        if (i == 0) begin ready_i = 1'b0; end
        tick();
      end
    end
    chk("R8", done_o, 1'b1);
    tick();
    chk("R8", done_o, 1'b0);

    // R5 + R7: read sequence with inputs flipped mid-cycle
    read_i = 1'b1; ready_i = 1'b1;
    wait_state(8'hA8, 20);
    pause_i = 1'b1; ready_i = 1'b0; read_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk("R5", state_o, rd_seq[i]);
      if (i < 5) tick();
    end
    chk("R7", done_o, 1'b1);

    // R9: abort mid-cycle
    pause_i = 1'b0; ready_i = 1'b1; read_i = 1'b0;
    wait_state(8'h21, 20);
    reset_i = 1'b1;
    tick();
    chk("R9", state_o, 8'h04);
    reset_i = 1'b0;
    ready_i = 1'b0;
    starts = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (done_o) starts++;
    end
    chk("R9", starts, 0);
    chk("R2", state_o inside {8'h00, 8'h01, 8'h03}, 1'b1);

    // R7/R3: random stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) ready_i = $urandom_range(3) != 0;
      if ($urandom_range(5) == 0) pause_i = $urandom_range(3) == 0;
      if ($urandom_range(7) == 0) read_i  = $urandom_range(1);
      reset_i = ($urandom_range(99) == 0);
      tick();
    end
    reset_i = 1'b0;
    ticks(4);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule